// File: doc/BRIEF.md
# Queue Run/Halt Command Register

This block is the software-facing control point for up to eight DMA queues that serve one direction of a network port. A single register write can start any set of queues, through the low byte, and request a halt of any set of queues, through the upper byte, which mirrors the low byte bit for bit. The block drives one run line per queue to the downstream DMA engines. Each engine returns a quiescence flag.

A halt does not take effect at once. A halt request marks the queue as draining. Its run bit stays set, and keeps reading back as 1, until the engine reports it has gone quiet. Only then does the bit fall. To shut a port down, software reads the register, writes the low byte back shifted up by eight so that only the running queues are halted, and polls until the low byte reads zero.

Top module: `qrun_cmd_reg`

## Requirements
- R1: A synchronous active-low reset clears every run bit and every pending halt, so all `q_run` outputs and the whole of `reg_rdata` are 0 after reset.
- R2: A write with bit q of `reg_wdata` set, and bit q+8 clear, sets run bit q. `q_run[q]` and `reg_rdata[q]` read 1 from the cycle after the write.
- R3: Writing 0 to any bit has no effect. Queues whose start bit and halt bit are both 0 in a write keep their state.
- R4: A write with bit q+8 set, while queue q is running, records a pending halt. Run bit q stays 1 for as long as `q_idle[q]` stays low.
- R5: With a halt pending, run bit q clears at the first clock edge at which `q_idle[q]` is high, and the pending halt clears with it. The earliest such edge is the one after the halt write, so a run bit always stays set for at least one cycle after its halt request.
- R6: Bits [15:8] of `reg_rdata` always read 0, because halt requests are self-clearing.
- R7: If one write sets both bit q and bit q+8, the halt wins. A running queue starts draining, and a stopped queue stays stopped.
- R8: A halt request for a queue that is not running is ignored and leaves nothing pending. A later start of that queue holds even while `q_idle` is high.
- R9: A start request for a queue that already has a halt pending is ignored. The queue still drains and clears once it goes idle.
- R10: `reg_rdata[7:0]` equals the set of running queues. Writing that byte shifted left by eight halts exactly those queues, and the low byte then reaches zero once all of them are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command register |
| reg_wdata | input | 16 | Write data: [7:0] start requests, [15:8] halt requests |
| reg_rdata | output | 16 | Read data: [7:0] run bits, [15:8] always zero |
| q_run | output | 8 | Per-queue run line to the DMA engines |
| q_idle | input | 8 | Per-queue quiescence flag from the DMA engines |

## Verification
The checker watches several rules on every cycle. A run bit may only rise after a start write with a clear halt bit. It may only fall in a cycle that followed a high idle flag. It never falls in the cycle right after a halt write. The upper read byte stays zero, and reset empties all queues. The bench scenarios cover the behaviour that depends on history. These are a halt held back by a busy engine, a halt aimed at a stopped queue leaving no trace, a start ignored during draining, simultaneous start and halt, and the read-shift-poll shutdown sequence.

// File: rtl/qrun_pkg.sv
// Shared definitions for the queue run/halt command register.
// Assumes at most eight queues so the halt byte sits directly above the start byte.
package qrun_pkg;
    localparam int unsigned DEF_QUEUES = 8;

    // Per-queue state: running flag and outstanding halt
    typedef struct packed {
        logic run;
        logic halt_pend;
    } slot_state_t;
endpackage

// File: rtl/qrun_decode.sv
// Splits a register write into per-queue start and halt strobes.
// Assumes the halt field mirrors the start field, NQ bits higher.
// A halt bit masks the start bit of the same queue.
module qrun_decode #(
    parameter int unsigned NQ = 8,
    localparam int unsigned DW = 2 * NQ
) (
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [NQ-1:0] start_q,
    output logic [NQ-1:0] halt_q
);
    // Derive strobes; halt has priority over start for the same queue
    always_comb begin
        halt_q  = wr ? wdata[DW-1:NQ] : '0;
        start_q = wr ? (wdata[NQ-1:0] & ~wdata[DW-1:NQ]) : '0;
    end
endmodule

// File: rtl/qrun_slot.sv
// State for one queue: run bit plus pending-halt flag.
// Assumes the start and halt strobes are single-cycle and mutually exclusive.
// The run bit falls only when a halt is pending and the engine reports idle.
module qrun_slot
    import qrun_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic halt_i,
    input  logic idle_i,
    output logic run_o
);
    slot_state_t st;

    // Advance run/halt state: drain completion first, then new requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (st.halt_pend && idle_i) begin
            st.run       <= 1'b0;
            st.halt_pend <= 1'b0;
        end else if (halt_i && st.run) begin
            st.halt_pend <= 1'b1;
        end else if (start_i && !st.halt_pend) begin
            st.run <= 1'b1;
        end
    end

    assign run_o = st.run;
endmodule

// File: rtl/qrun_cmd_reg.sv
// Queue run/halt command register for one port direction.
// Assumes one write port and a combinational read of the current state.
// Halts wait for per-queue idle before the run bit drops.
module qrun_cmd_reg #(
    parameter int unsigned NUM_QUEUES = qrun_pkg::DEF_QUEUES,
    localparam int unsigned REG_W = 2 * NUM_QUEUES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic [NUM_QUEUES-1:0] q_run,
    input  logic [NUM_QUEUES-1:0] q_idle
);
    logic [NUM_QUEUES-1:0] start_q;
    logic [NUM_QUEUES-1:0] halt_q;

    qrun_decode #(.NQ(NUM_QUEUES)) u_dec (
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .start_q (start_q),
        .halt_q  (halt_q)
    );

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_slot
        qrun_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_q[q]),
            .halt_i  (halt_q[q]),
            .idle_i  (q_idle[q]),
            .run_o   (q_run[q])
        );
    end

    // Read view: run bits low, halt field always zero
    always_comb begin
        reg_rdata = '0;
        reg_rdata[NUM_QUEUES-1:0] = q_run;
    end
endmodule

// File: rtl/qrun_cmd_reg_chk.sv
// Port-level checker for the queue run/halt command register.
module qrun_cmd_reg_chk #(
    parameter int unsigned NUM_QUEUES = 8,
    localparam int unsigned REG_W = 2 * NUM_QUEUES
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [REG_W-1:0]      reg_wdata,
    input logic [REG_W-1:0]      reg_rdata,
    input logic [NUM_QUEUES-1:0] q_run,
    input logic [NUM_QUEUES-1:0] q_idle
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) !rst_n |=> (q_run == '0));

    // R6
    halt_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:NUM_QUEUES] == '0);

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
        // R2
        run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q_run[q]) |-> $past(reg_wr && reg_wdata[q] && !reg_wdata[q+NUM_QUEUES]));

        // R5
        run_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q_run[q]) |-> $past(q_idle[q]));

        // R4
        halt_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_run[q] && reg_wr && reg_wdata[q+NUM_QUEUES]) |=> q_run[q]);
    end
endmodule

bind qrun_cmd_reg qrun_cmd_reg_chk #(.NUM_QUEUES(NUM_QUEUES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .q_run     (q_run),
    .q_idle    (q_idle)
);

// File: tb/sim_qrun_cmd_reg.sv
// Directed bench for the queue run/halt command register.
module sim_qrun_cmd_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  q_run;
    logic [7:0]  q_idle = 8'hFF;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    qrun_cmd_reg u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .q_run     (q_run),
        .q_idle    (q_idle)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One-cycle register write; returns at the negedge after the write edge
    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        q_idle = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 run", {8'h0, q_run}, 16'h0000);
        check("R1 rdata", reg_rdata, 16'h0000);
    endtask

    task automatic t_start();
        wr(16'h0005);
        check("R2 start q0,q2", {8'h0, q_run}, 16'h0005);
        check("R10 read mirrors", reg_rdata, 16'h0005);
        wr(16'h0080);
        check("R3 zero bits keep q0,q2", {8'h0, q_run}, 16'h0085);
        wr(16'h0000);
        check("R3 all-zero write", reg_rdata, 16'h0085);
    endtask

    task automatic t_busy_halt();
        do_reset();
        q_idle = 8'hFB;
        wr(16'h0004);
        wr(16'h0400);
        check("R6 halt field reads 0", reg_rdata, 16'h0004);
        repeat (3) @(negedge clk);
        check("R4 held while busy", {8'h0, q_run}, 16'h0004);
        q_idle = 8'hFF;
        @(negedge clk);
        check("R5 clears on idle", {8'h0, q_run}, 16'h0000);
        wr(16'h0004);
        check("R5 pending cleared, restart", {8'h0, q_run}, 16'h0004);
        @(negedge clk);
        check("R5 restart holds", {8'h0, q_run}, 16'h0004);
    endtask

    task automatic t_idle_halt();
        do_reset();
        wr(16'h0002);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 16'h0200;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
        check("R5 min one cycle after halt", {8'h0, q_run}, 16'h0002);
        @(negedge clk);
        check("R5 cleared next edge", {8'h0, q_run}, 16'h0000);
    endtask

    task automatic t_both();
        do_reset();
        wr(16'h1010);
        check("R7 stopped queue stays off", {8'h0, q_run}, 16'h0000);
        q_idle = 8'hFE;
        wr(16'h0001);
        wr(16'h0101);
        @(negedge clk);
        check("R7 running queue drains", {8'h0, q_run}, 16'h0001);
        q_idle = 8'hFF;
        @(negedge clk);
        check("R7 drained", {8'h0, q_run}, 16'h0000);
    endtask

    task automatic t_halt_inactive();
        do_reset();
        wr(16'h1000);
        wr(16'h0010);
        repeat (3) @(negedge clk);
        check("R8 no stale halt", {8'h0, q_run}, 16'h0010);
    endtask

    task automatic t_start_during_drain();
        do_reset();
        q_idle = 8'hDF;
        wr(16'h0020);
        wr(16'h2000);
        wr(16'h0020);
        check("R9 still running", {8'h0, q_run}, 16'h0020);
        q_idle = 8'hFF;
        @(negedge clk);
        check("R9 start ignored, drained", {8'h0, q_run}, 16'h0000);
    endtask

    task automatic t_shutdown();
        logic [15:0] snap;
        do_reset();
        q_idle = 8'h00;
        wr(16'h00C9);
        snap = reg_rdata;
        check("R10 snapshot", snap, 16'h00C9);
        wr({snap[7:0], 8'h00});
        q_idle = 8'h08;
        @(negedge clk);
        check("R10 partial drain", reg_rdata, 16'h00C1);
        q_idle = 8'hFF;
        @(negedge clk);
        check("R10 all stopped", reg_rdata, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_start();
        t_busy_halt();
        t_idle_halt();
        t_both();
        t_halt_inactive();
        t_start_during_drain();
        t_shutdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule